// File: doc/BRIEF.md
# Accumulator Rotate and Decimal Adjust Unit

This unit carries out the single-byte instructions of an 8-bit CPU that work only on the accumulator and the flags. It takes the accumulator, the four flags (zero, subtract, half-carry, carry) and a 3-bit operation code. It produces the new accumulator and flags. There are four rotates, two carry-flag operations, a one's complement of the accumulator, and a BCD decimal adjust. The decimal adjust uses the stored subtract and half-carry flags to choose the correction.

All computation is combinational. The result goes into output registers in the clock cycle where the enable is high, and holds until the next enable. The flags travel as a 4-bit vector: bit 3 is zero (Z), bit 2 is subtract (N), bit 1 is half-carry (H) and bit 0 is carry (C). The operation code matches bits 5:3 of the instruction byte that the surrounding decoder extracts.

Top module: `afu_core`

## Requirements
- R1: Operation code 0 (rotate left circular): the result is the accumulator shifted left by one, with the old bit 7 placed in bit 0. C takes the old bit 7.
- R2: Operation code 1 (rotate right circular): the result is the accumulator shifted right by one, with the old bit 0 placed in bit 7. C takes the old bit 0.
- R3: Operation code 2 (rotate left through carry): the result is the accumulator shifted left by one, with the incoming C in bit 0. C takes the old bit 7.
- R4: Operation code 3 (rotate right through carry): the result is the accumulator shifted right by one, with the incoming C in bit 7. C takes the old bit 0.
- R5: After any of operation codes 0 to 3, Z, N and H are all 0, even when the result is 0x00.
- R6: Operation code 4 (decimal adjust) with N=0 builds a correction from two parts. It adds 0x60 and sets C when the incoming C is 1 or the accumulator is above 0x99; otherwise C is 0. It adds 0x06 when the incoming H is 1 or the low nibble is above 9. Both tests use the incoming accumulator, and the sum is taken modulo 256.
- R7: Operation code 4 with N=1 subtracts the correction. It subtracts 0x60 only if the incoming C is 1 and 0x06 only if the incoming H is 1. It applies no digit-range test, and C is unchanged.
- R8: After operation code 4, H is 0, N keeps its incoming value, and Z is 1 exactly when the 8-bit result is 0x00.
- R9: Operation code 5 (complement accumulator) inverts all 8 accumulator bits and sets N and H. Z and C are unchanged.
- R10: Operation code 6 forces C to 1 and operation code 7 inverts C. Both clear N and H, and leave Z and the accumulator unchanged.
- R11: Synchronous active-high reset sets the accumulator output and flags output to 0. The outputs take the new result one clock edge after a cycle with en=1, and they hold their value while en=0, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Latch the result of the current inputs at this edge |
| op | input | 3 | Operation code (0..7, see requirements) |
| acc_in | input | 8 | Accumulator value before the operation |
| flags_in | input | 4 | Flags before the operation, {Z,N,H,C} |
| acc_out | output | 8 | Registered accumulator result |
| flags_out | output | 4 | Registered flags result, {Z,N,H,C} |

## Verification
The unit keeps no state apart from its output registers. A wrong result therefore shows up at acc_out or flags_out on the edge right after the enable, and nothing else delays it. The registers are checked with enable pulses, with changes to the inputs while the enable is low, and through reset. The bench runs every accumulator value with every flag combination for all eight operation codes. This reaches each decimal-adjust correction path, including a wrong choice between the stored-flag test and the digit-range test, and every carry fed into or out of a rotate.

// File: rtl/afu_pkg.sv
package afu_pkg;

  typedef enum logic [2:0] {
    OP_ROT_LC  = 3'd0,
    OP_ROT_RC  = 3'd1,
    OP_ROT_LT  = 3'd2,
    OP_ROT_RT  = 3'd3,
    OP_BCD_ADJ = 3'd4,
    OP_INV_ACC = 3'd5,
    OP_SET_CY  = 3'd6,
    OP_INV_CY  = 3'd7
  } afu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } afu_flags_t;

  localparam int FLAG_W = $bits(afu_flags_t);

endpackage

// File: rtl/afu_rotate.sv
module afu_rotate #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic              cin_i,
  input  logic              right_i,
  input  logic              thru_i,
  output logic [DATA_W-1:0] val_o,
  output logic              cout_o
);
  localparam int MSB = DATA_W - 1;

  logic fill_left;
  logic fill_right;

  // The bit shifted in comes either from the carry or from the opposite end.
  assign fill_left  = thru_i ? cin_i : val_i[MSB];
  assign fill_right = thru_i ? cin_i : val_i[0];

  always_comb begin
    if (right_i) begin
      val_o  = {fill_right, val_i[MSB:1]};
      cout_o = val_i[0];
    end else begin
      val_o  = {val_i[MSB-1:0], fill_left};
      cout_o = val_i[MSB];
    end
  end

endmodule

// File: rtl/afu_bcd_adjust.sv
module afu_bcd_adjust #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic              sub_i,
  input  logic              hc_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] val_o,
  output logic              cy_o
);
  localparam int DIG_W = DATA_W / 2;
  localparam logic [DIG_W-1:0]  DIG_MAX = DIG_W'(9);
  localparam logic [DATA_W-1:0] BYTE_MAX = DATA_W'((9 << DIG_W) | 9);
  localparam logic [DATA_W-1:0] FIX_LO = DATA_W'(6);
  localparam logic [DATA_W-1:0] FIX_HI = DATA_W'(6 << DIG_W);

  logic              lo_fix;
  logic              hi_fix;
  logic [DATA_W-1:0] corr;

  always_comb begin
    if (sub_i) begin
      // After a subtraction only the stored flags choose the corrections.
      lo_fix = hc_i;
      hi_fix = cy_i;
    end else begin
      lo_fix = hc_i || (val_i[DIG_W-1:0] > DIG_MAX);
      hi_fix = cy_i || (val_i > BYTE_MAX);
    end
    corr = (lo_fix ? FIX_LO : '0) | (hi_fix ? FIX_HI : '0);
    val_o = sub_i ? (val_i - corr) : (val_i + corr);
    cy_o  = sub_i ? cy_i : hi_fix;
  end

endmodule

// File: rtl/afu_flag_ops.sv
module afu_flag_ops
  import afu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  afu_op_e           op_i,
  input  logic [DATA_W-1:0] val_i,
  input  afu_flags_t        flg_i,
  output logic [DATA_W-1:0] val_o,
  output afu_flags_t        flg_o
);
  always_comb begin
    val_o = val_i;
    flg_o = flg_i;
    unique case (op_i)
      OP_INV_ACC: begin
        val_o   = ~val_i;
        flg_o.n = 1'b1;
        flg_o.h = 1'b1;
      end
      OP_SET_CY: begin
        flg_o.c = 1'b1;
        flg_o.n = 1'b0;
        flg_o.h = 1'b0;
      end
      OP_INV_CY: begin
        flg_o.c = ~flg_i.c;
        flg_o.n = 1'b0;
        flg_o.h = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/afu_core.sv
module afu_core
  import afu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [3:0]        flags_in,
  output logic [DATA_W-1:0] acc_out,
  output logic [3:0]        flags_out
);
  afu_op_e    op_e;
  afu_flags_t flg_in;
  afu_flags_t flg_nx;
  afu_flags_t flg_q;
  afu_flags_t flg_misc;

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_nx;
  logic [DATA_W-1:0] rot_val;
  logic              rot_cy;
  logic [DATA_W-1:0] bcd_val;
  logic              bcd_cy;
  logic [DATA_W-1:0] misc_val;
  logic              is_rot;

  assign op_e   = afu_op_e'(op);
  assign flg_in = afu_flags_t'(flags_in);
  // Codes 0..3 are the rotates: bit 0 picks the direction, bit 1 the carry path.
  assign is_rot = (op[2] == 1'b0);

  afu_rotate #(.DATA_W(DATA_W)) u_rot (
    .val_i   (acc_in),
    .cin_i   (flg_in.c),
    .right_i (op[0]),
    .thru_i  (op[1]),
    .val_o   (rot_val),
    .cout_o  (rot_cy)
  );

  afu_bcd_adjust #(.DATA_W(DATA_W)) u_bcd (
    .val_i (acc_in),
    .sub_i (flg_in.n),
    .hc_i  (flg_in.h),
    .cy_i  (flg_in.c),
    .val_o (bcd_val),
    .cy_o  (bcd_cy)
  );

  afu_flag_ops #(.DATA_W(DATA_W)) u_misc (
    .op_i  (op_e),
    .val_i (acc_in),
    .flg_i (flg_in),
    .val_o (misc_val),
    .flg_o (flg_misc)
  );

  always_comb begin
    if (is_rot) begin
      acc_nx = rot_val;
      flg_nx = '{z: 1'b0, n: 1'b0, h: 1'b0, c: rot_cy};
    end else if (op_e == OP_BCD_ADJ) begin
      acc_nx = bcd_val;
      flg_nx = '{z: (bcd_val == '0), n: flg_in.n, h: 1'b0, c: bcd_cy};
    end else begin
      acc_nx = misc_val;
      flg_nx = flg_misc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      flg_q <= '0;
    end else if (en) begin
      acc_q <= acc_nx;
      flg_q <= flg_nx;
    end
  end

  assign acc_out   = acc_q;
  assign flags_out = flg_q;

  a_r5_rot_flags_clear: assert property (@(posedge clk) disable iff (rst)
    (en && op[2] == 1'b0) |=> (flags_out[3:1] == 3'b000));

  a_r9_inv_acc: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd5) |=> (acc_out == ~$past(acc_in)) && flags_out[2] && flags_out[1]);

  a_r10_set_cy: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd6) |=> flags_out[0] && (acc_out == $past(acc_in)));

  a_r10_keep_zero: assert property (@(posedge clk) disable iff (rst)
    (en && op[2:1] == 2'b11) |=> (flags_out[3] == $past(flags_in[3])) && !flags_out[1]);

  a_r8_bcd_flags: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd4) |=> !flags_out[1] && (flags_out[2] == $past(flags_in[2]))
                          && (flags_out[3] == (acc_out == '0)));

  a_r7_bcd_sub_keeps_cy: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd4 && flags_in[2]) |=> (flags_out[0] == $past(flags_in[0])));

  a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_out) && $stable(flags_out));

endmodule

// File: tb/afu_core_bench.sv
module afu_core_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic [2:0] op;
  logic [7:0] acc_in;
  logic [3:0] flags_in;
  logic [7:0] acc_out;
  logic [3:0] flags_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  afu_core u_afu_core (
    .clk(clk), .rst(rst), .en(en), .op(op), .acc_in(acc_in),
    .flags_in(flags_in), .acc_out(acc_out), .flags_out(flags_out)
  );

  // {op(4), acc(8), flags(4), exp acc(8), exp flags(4)}
  localparam int NVEC = 18;
  localparam logic [27:0] VEC [NVEC] = '{
    {4'd0, 8'h80, 4'b0000, 8'h01, 4'b0001},
    {4'd0, 8'h00, 4'b1000, 8'h00, 4'b0000},
    {4'd1, 8'h01, 4'b0000, 8'h80, 4'b0001},
    {4'd2, 8'h80, 4'b0000, 8'h00, 4'b0001},
    {4'd2, 8'h00, 4'b0001, 8'h01, 4'b0000},
    {4'd3, 8'h01, 4'b0000, 8'h00, 4'b0001},
    {4'd3, 8'h00, 4'b0111, 8'h80, 4'b0000},
    {4'd4, 8'h9A, 4'b0000, 8'h00, 4'b1001},
    {4'd4, 8'h11, 4'b0010, 8'h17, 4'b0000},
    {4'd4, 8'h99, 4'b0000, 8'h99, 4'b0000},
    {4'd4, 8'h00, 4'b0001, 8'h60, 4'b0001},
    {4'd4, 8'h0F, 4'b0110, 8'h09, 4'b0100},
    {4'd4, 8'hF0, 4'b0101, 8'h90, 4'b0101},
    {4'd4, 8'h0A, 4'b0100, 8'h0A, 4'b0100},
    {4'd5, 8'h5A, 4'b1001, 8'hA5, 4'b1111},
    {4'd6, 8'h33, 4'b1110, 8'h33, 4'b1001},
    {4'd7, 8'h33, 4'b0111, 8'h33, 4'b0000},
    {4'd7, 8'h33, 4'b1000, 8'h33, 4'b1001}
  };

  function automatic string acc_req(int o, int f);
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return ((f & 4) != 0) ? "R7" : "R6";
      5: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic string flg_req(int o);
    if (o < 4) return "R5";
    if (o == 4) return "R8";
    if (o == 5) return "R9";
    return "R10";
  endfunction

  // Independent reference: returns {acc, flags}
  function automatic logic [11:0] model(int o, int a, int f);
    int z = (f >> 3) & 1, n = (f >> 2) & 1, h = (f >> 1) & 1, c = f & 1;
    int r = a;
    int corr = 0;
    case (o)
      0: begin r = (a * 2) % 256 + a / 128; c = a / 128; z = 0; n = 0; h = 0; end
      1: begin r = a / 2 + (a % 2) * 128; c = a % 2; z = 0; n = 0; h = 0; end
      2: begin r = (a * 2) % 256 + c; c = a / 128; z = 0; n = 0; h = 0; end
      3: begin r = a / 2 + c * 128; c = a % 2; z = 0; n = 0; h = 0; end
      4: begin
        if (n == 0) begin
          if (c == 1 || a > 153) begin corr += 96; c = 1; end
          if (h == 1 || (a % 16) > 9) corr += 6;
          r = (a + corr) % 256;
        end else begin
          if (c == 1) corr += 96;
          if (h == 1) corr += 6;
          r = (a - corr + 256) % 256;
        end
        h = 0;
        z = (r == 0) ? 1 : 0;
      end
      5: begin r = 255 - a; n = 1; h = 1; end
      6: begin c = 1; n = 0; h = 0; end
      default: begin c = 1 - c; n = 0; h = 0; end
    endcase
    return {r[7:0], z[0], n[0], h[0], c[0]};
  endfunction

  task automatic run_one(int o, int a, int f, logic [7:0] ea, logic [3:0] ef);
    @(negedge clk);
    op = o[2:0]; acc_in = a[7:0]; flags_in = f[3:0]; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    checks++;
    if (acc_out !== ea) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h f=%b acc actual=%02h expected=%02h",
               acc_req(o, f), o, a, f, acc_out, ea);
    end
    checks++;
    if (flags_out !== ef) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h f=%b flags actual=%b expected=%b",
               flg_req(o), o, a, f, flags_out, ef);
    end
  endtask

  task automatic check_out(string req, logic [7:0] ea, logic [3:0] ef);
    checks++;
    if (acc_out !== ea || flags_out !== ef) begin
      errors++;
      $display("FAIL %s actual=%02h/%b expected=%02h/%b", req, acc_out, flags_out, ea, ef);
    end
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; op = '0; acc_in = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_out("R11 reset", 8'h00, 4'b0000);

    // Directed corner vectors
    for (int i = 0; i < NVEC; i++)
      run_one(int'(VEC[i][27:24]), int'(VEC[i][23:16]), int'(VEC[i][15:12]),
              VEC[i][11:4], VEC[i][3:0]);

    // R11: inputs change while en=0, outputs must hold
    run_one(5, 8'h0F, 4'b0000, 8'hF0, 4'b0110);
    @(negedge clk);
    op = 3'd0; acc_in = 8'h81; flags_in = 4'b1111;
    repeat (3) @(negedge clk);
    check_out("R11 hold", 8'hF0, 4'b0110);

    // Exhaustive sweep: every op, accumulator value and flag combination
    for (int o = 0; o < 8; o++)
      for (int f = 0; f < 16; f++)
        for (int a = 0; a < 256; a++) begin
          logic [11:0] m;
          m = model(o, a, f);
          run_one(o, a, f, m[11:4], m[3:0]);
        end

    // R11: reset clears registered result
    run_one(5, 8'h00, 4'b0000, 8'hFF, 4'b0110);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_out("R11 reset after use", 8'h00, 4'b0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule